// File: doc/BRIEF.md
# Paired dual-compare 8-bit timer

This block holds two identical timer channels. Each channel counts up through an 8-bit counter driven by a selectable prescaled rate, compares the count against two constant registers, A and B, and raises a sticky flag when either comparison starts to hold or when the counter wraps. One output pin per channel is driven low, driven high or toggled by the A and B match events. Each event acts under its own 2-bit output action field. A clear-mode field lets the counter restart on match A, on match B or on an external clear input, which turns the channel into a programmable period or pulse-width generator.

A simple synchronous register port reaches every register of both channels. For the counter and the two constant registers, a word access pairs the channels into one 16-bit register. Channel 0 supplies the high byte and channel 1 the low byte, so software can run the pair as a single 16-bit quantity.

Top module: `tmr_pair`

## Requirements
- R1: After reset every counter reads 0x00, every constant register reads 0xFF, the control and status registers read 0x00 and both output pins are low.
- R2: The control field sel (control bits [2:0]) chooses the count rate. sel=0 holds the counter. sel=1 counts every clock. sel=k for k from 2 to 7 counts in the cycles where the number of cycles since reset release, modulo 2^(k-1), equals 2^(k-1)-1.
- R3: A count step from 0xFF to 0x00 sets the overflow flag (status bit 2). A wrap caused by a bus write or a clear does not set it.
- R4: A match event on A (or B) occurs in the first cycle in which the counter equals that constant. The event sets flag A (status bit 0) or flag B (status bit 1) at the following clock edge. A match that lasts several cycles gives only one event.
- R5: The clear-mode field (control bits [4:3]) selects what clears the counter: 0 = nothing, 1 = match A event, 2 = match B event, 3 = external clear input held high. The counter reads 0x00 after the clock edge that ends the cycle in which the clear condition holds.
- R6: A bus write to the counter takes priority over clearing and counting in the same cycle. The written value is read back in the next cycle.
- R7: In the cycle in which a constant register is written, that register gives no match event. A match against the new value can give an event in the next cycle.
- R8: The output action fields (status bits [4:3] for A, bits [6:5] for B) are encoded 0 = no change, 1 = drive low, 2 = drive high, 3 = toggle. The pin updates at the edge after the event. If both events occur in the same cycle, only the B action applies.
- R9: A status flag clears only when a status write holds 0 in its bit position after a status read has returned that flag as 1. Any status write ends that arming. A hardware set in the same cycle as a clearing write keeps the flag at 1.
- R10: A word access (bus_word=1) to the counter or a constant register writes bus_wdata[15:8] to channel 0 and bus_wdata[7:0] to channel 1. It reads back {channel 0, channel 1}.
- R11: The register index is bus_addr[3:1] (0 control, 1 status, 2 counter, 3 constant A, 4 constant B) and bus_addr[0] picks the channel for byte access. A byte read returns the value in bits [7:0] with zero upper bits. Indices 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 16-bit paired access to counter or constants |
| bus_addr | input | 4 | Register index [3:1], channel [0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address |
| ext_clr | input | 2 | External counter clear, one per channel |
| tmo | output | 2 | Timer output pin, one per channel |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a 3-bit rate select. The full 256-value wrap and the divide-by-64 rate therefore fit into a few thousand cycles. With these values, random constants and counter writes reach every counter value, so overflow, both match orders, same-cycle A and B matches and matches against a constant being written all occur. Word accesses, the arming protocol and write-versus-hardware-set collisions are reached on both channels at once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int REG_IDX_W = 3;

  localparam logic [REG_IDX_W-1:0] RI_CTRL = 3'd0;
  localparam logic [REG_IDX_W-1:0] RI_STAT = 3'd1;
  localparam logic [REG_IDX_W-1:0] RI_CNT  = 3'd2;
  localparam logic [REG_IDX_W-1:0] RI_CMA  = 3'd3;
  localparam logic [REG_IDX_W-1:0] RI_CMB  = 3'd4;

  typedef enum logic [1:0] {
    OS_KEEP   = 2'b00,
    OS_LOW    = 2'b01,
    OS_HIGH   = 2'b10,
    OS_TOGGLE = 2'b11
  } pin_act_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_CMA  = 2'b01,
    CLR_CMB  = 2'b10,
    CLR_EXT  = 2'b11
  } clr_mode_e;

  // Next pin level for one output action code.
  function automatic logic apply_pin_act(logic cur, logic [1:0] act);
    case (pin_act_e'(act))
      OS_LOW:    return 1'b0;
      OS_HIGH:   return 1'b1;
      OS_TOGGLE: return ~cur;
      default:   return cur;
    endcase
  endfunction

  // Sticky flag: a hardware set beats an armed software clear.
  function automatic logic sticky_flag(logic flag, logic hw_set, logic sw_wr,
                                       logic armed, logic wbit);
    return hw_set | (flag & ~(sw_wr & armed & ~wbit));
  endfunction

  // Registers that two channels share as one word.
  function automatic logic is_pair_reg(logic [REG_IDX_W-1:0] idx);
    return (idx == RI_CNT) || (idx == RI_CMA) || (idx == RI_CMB);
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [(1<<SEL_W)-1:0] tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int PRE_W = NSEL - 2;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // tick[k]: every 2^(k-1) cycles, tick[0] never, tick[1] always
  for (genvar k = 0; k < NSEL; k++) begin : g_tap
    if (k == 0) begin : g_stop
      assign tick[k] = 1'b0;
    end else if (k == 1) begin : g_full
      assign tick[k] = 1'b1;
    end else begin : g_div
      assign tick[k] = &pre_q[k-2:0];
    end
  end

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cnst,
  input  logic         wr_hold,
  output logic         match_ev
);
  logic eq_now;
  logic eq_q;

  assign eq_now   = (cnt == cnst) && !wr_hold;
  assign match_ev = eq_now && !eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_now;
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<SEL_W)-1:0] tick_sel,
  input  logic                  ext_clr,
  input  logic                  wr_ctrl,
  input  logic                  wr_stat,
  input  logic                  wr_cnt,
  input  logic                  wr_cma,
  input  logic                  wr_cmb,
  input  logic                  rd_stat,
  input  logic [CNT_W-1:0]      wdata,
  output logic [CNT_W-1:0]      ctrl_rd,
  output logic [CNT_W-1:0]      stat_rd,
  output logic [CNT_W-1:0]      cnt_rd,
  output logic [CNT_W-1:0]      cma_rd,
  output logic [CNT_W-1:0]      cmb_rd,
  output logic                  tmo
);
  localparam int NFLAG   = 3;
  localparam int CLR_LSB = SEL_W;
  localparam int OSA_LSB = NFLAG;
  localparam int OSB_LSB = NFLAG + 2;

  logic [SEL_W-1:0] sel_q;
  logic [1:0]       clr_q;
  logic [1:0]       os_a_q, os_b_q;
  logic [CNT_W-1:0] cnt_q, cma_q, cmb_q;
  logic [NFLAG-1:0] flag_q, arm_q, flag_nx, arm_nx;
  logic             tick, clr_now, ovf_ev, ev_a, ev_b;
  logic [1:0]       cmp_ev;
  logic [CNT_W-1:0] cmp_val [2];
  logic [1:0]       cmp_hold;

  assign tick = tick_sel[sel_q];

  // Two compare units, one per constant register
  assign cmp_val[0] = cma_q;
  assign cmp_val[1] = cmb_q;
  assign cmp_hold   = {wr_cmb, wr_cma};

  for (genvar i = 0; i < 2; i++) begin : g_cmp
    tmr_compare #(.W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt_q),
      .cnst     (cmp_val[i]),
      .wr_hold  (cmp_hold[i]),
      .match_ev (cmp_ev[i])
    );
  end

  assign ev_a = cmp_ev[0];
  assign ev_b = cmp_ev[1];

  always_comb begin
    case (clr_mode_e'(clr_q))
      CLR_CMA: clr_now = ev_a;
      CLR_CMB: clr_now = ev_b;
      CLR_EXT: clr_now = ext_clr;
      default: clr_now = 1'b0;
    endcase
  end

  assign ovf_ev = !wr_cnt && !clr_now && tick && (cnt_q == '1);

  // Counter: bus write, then clear, then count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= wdata;
    else if (clr_now) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cma_q <= '1;
      cmb_q <= '1;
    end else begin
      if (wr_cma) cma_q <= wdata;
      if (wr_cmb) cmb_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      clr_q  <= '0;
      os_a_q <= '0;
      os_b_q <= '0;
    end else begin
      if (wr_ctrl) begin
        sel_q <= wdata[SEL_W-1:0];
        clr_q <= wdata[CLR_LSB+1:CLR_LSB];
      end
      if (wr_stat) begin
        os_a_q <= wdata[OSA_LSB+1:OSA_LSB];
        os_b_q <= wdata[OSB_LSB+1:OSB_LSB];
      end
    end
  end

  // Flags with read-then-write-zero arming
  logic [NFLAG-1:0] hw_set;
  assign hw_set = {ovf_ev, ev_b, ev_a};

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_comb begin
      flag_nx[f] = sticky_flag(flag_q[f], hw_set[f], wr_stat, arm_q[f], wdata[f]);
      if (!flag_nx[f])                arm_nx[f] = 1'b0;
      else if (wr_stat)               arm_nx[f] = 1'b0;
      else if (rd_stat && flag_q[f])  arm_nx[f] = 1'b1;
      else                            arm_nx[f] = arm_q[f];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= flag_nx;
      arm_q  <= arm_nx;
    end
  end

  // Output pin: B event action wins over A
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmo <= 1'b0;
    else if (ev_b) tmo <= apply_pin_act(tmo, os_b_q);
    else if (ev_a) tmo <= apply_pin_act(tmo, os_a_q);
  end

  assign ctrl_rd = CNT_W'({clr_q, sel_q});
  assign stat_rd = CNT_W'({os_b_q, os_a_q, flag_q});
  assign cnt_rd  = cnt_q;
  assign cma_rd  = cma_q;
  assign cmb_rd  = cmb_q;

  // R6: a bus write lands regardless of clear or count
  a_r6_cnt_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wdata));

  // R2: stopped rate holds the counter
  a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0 && !wr_cnt && !clr_now) |=> $stable(cnt_q));

  // R3: wrap by counting sets overflow
  a_r3_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> flag_q[2]);

  // R4: match events set their flags
  a_r4_flag_a: assert property (@(posedge clk) disable iff (!rst_n)
    ev_a |=> flag_q[0]);
  a_r4_flag_b: assert property (@(posedge clk) disable iff (!rst_n)
    ev_b |=> flag_q[1]);

  // R5: clear on match A
  a_r5_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && clr_q == CLR_CMA && ev_a) |=> cnt_q == '0);

  // R7: writing constant A cannot raise flag A
  a_r7_no_match_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cma && !flag_q[0]) |=> !flag_q[0]);

  // R8: output actions and B priority
  a_r8_b_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_b && os_b_q == OS_LOW) |=> !tmo);
  a_r8_a_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_a && !ev_b && os_a_q == OS_HIGH) |=> tmo);

  // R9: an unarmed write leaves a flag set
  a_r9_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && flag_q[0] && !arm_q[0]) |=> flag_q[0]);

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic                   bus_word,
  input  logic [REG_IDX_W:0]     bus_addr,
  input  logic [2*CNT_W-1:0]     bus_wdata,
  output logic [2*CNT_W-1:0]     bus_rdata,
  input  logic [1:0]             ext_clr,
  output logic [1:0]             tmo
);
  localparam int NCH    = 2;
  localparam int DATA_W = 2 * CNT_W;
  localparam int NSEL   = 1 << SEL_W;

  logic [REG_IDX_W-1:0] idx;
  logic                 ch_pick, word_op;
  logic [NSEL-1:0]      tick;
  logic [CNT_W-1:0]     rd_byte [NCH];

  assign idx     = bus_addr[REG_IDX_W:1];
  assign ch_pick = bus_addr[0];
  assign word_op = bus_word && is_pair_reg(idx);

  tmr_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic             hit, wr_go;
    logic [CNT_W-1:0] wd;
    logic [CNT_W-1:0] r_ctrl, r_stat, r_cnt, r_cma, r_cmb;

    assign hit   = bus_sel && (word_op || (ch_pick == c[0]));
    assign wr_go = hit && bus_wr;
    if (c == 0) begin : g_hi
      assign wd = word_op ? bus_wdata[DATA_W-1:CNT_W] : bus_wdata[CNT_W-1:0];
    end else begin : g_lo
      assign wd = bus_wdata[CNT_W-1:0];
    end

    tmr_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_sel (tick),
      .ext_clr  (ext_clr[c]),
      .wr_ctrl  (wr_go && idx == RI_CTRL),
      .wr_stat  (wr_go && idx == RI_STAT),
      .wr_cnt   (wr_go && idx == RI_CNT),
      .wr_cma   (wr_go && idx == RI_CMA),
      .wr_cmb   (wr_go && idx == RI_CMB),
      .rd_stat  (hit && !bus_wr && idx == RI_STAT),
      .wdata    (wd),
      .ctrl_rd  (r_ctrl),
      .stat_rd  (r_stat),
      .cnt_rd   (r_cnt),
      .cma_rd   (r_cma),
      .cmb_rd   (r_cmb),
      .tmo      (tmo[c])
    );

    always_comb begin
      case (idx)
        RI_CTRL: rd_byte[c] = r_ctrl;
        RI_STAT: rd_byte[c] = r_stat;
        RI_CNT:  rd_byte[c] = r_cnt;
        RI_CMA:  rd_byte[c] = r_cma;
        RI_CMB:  rd_byte[c] = r_cmb;
        default: rd_byte[c] = '0;
      endcase
    end
  end

  assign bus_rdata = word_op ? {rd_byte[0], rd_byte[1]}
                             : {{CNT_W{1'b0}}, rd_byte[ch_pick]};

  // R10: a word read on a paired register carries channel 1 in the low byte
  a_r10_word_low: assert property (@(posedge clk) disable iff (!rst_n)
    (word_op && !bus_wr) |-> bus_rdata[CNT_W-1:0] == rd_byte[1]);

endmodule

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 0, bus_wr = 0, bus_word = 0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  ext_clr = '0;
  logic [1:0]  tmo;

  int tests = 0, fails = 0;
  bit done = 0;

  // Reference state from the requirements
  int m_cnt[2], m_ca[2], m_cb[2], m_sel[2], m_clr[2], m_osa[2], m_osb[2];
  int m_flag[2][3], m_arm[2][3], m_eqa[2], m_eqb[2], m_tmo[2];
  int m_pre;
  bit [1:0] ext_v;

  tmr_pair dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ext_clr(ext_clr), .tmo(tmo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit rate_tick(int sel, int pre);
    int d;
    if (sel == 0) return 0;
    d = 1 << (sel - 1);
    return (pre % d) == d - 1;
  endfunction

  function automatic int pin_next(int cur, int os);
    case (os)
      1: return 0;
      2: return 1;
      3: return 1 - cur;
      default: return cur;
    endcase
  endfunction

  function automatic int byte_of(int c, int idx);
    case (idx)
      0: return m_sel[c] | (m_clr[c] << 3);
      1: return m_flag[c][0] | (m_flag[c][1] << 1) | (m_flag[c][2] << 2)
                | (m_osa[c] << 3) | (m_osb[c] << 5);
      2: return m_cnt[c];
      3: return m_ca[c];
      4: return m_cb[c];
      default: return 0;
    endcase
  endfunction

  function automatic int exp_read(bit wo, int a);
    int idx = a >> 1;
    if (wo && idx >= 2 && idx <= 4) return (byte_of(0, idx) << 8) | byte_of(1, idx);
    return byte_of(a & 1, idx);
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = 0; m_ca[c] = 255; m_cb[c] = 255; m_sel[c] = 0; m_clr[c] = 0;
      m_osa[c] = 0; m_osb[c] = 0; m_eqa[c] = 0; m_eqb[c] = 0; m_tmo[c] = 0;
      for (int i = 0; i < 3; i++) begin m_flag[c][i] = 0; m_arm[c][i] = 0; end
    end
    m_pre = 0;
  endtask

  task automatic model_step(bit s, bit w, bit wo, int a, int d);
    int idx, wdc, eqa, eqb, eva, evb, clr, ov, tk, cur, nf, na;
    bit hit, pair, wC, wA, wB, wS, wT, rS;
    int setv[3];
    idx = a >> 1;
    pair = wo && idx >= 2 && idx <= 4;
    for (int c = 0; c < 2; c++) begin
      hit = s && (pair || (a & 1) == c);
      wdc = pair ? ((c == 0) ? (d >> 8) & 255 : d & 255) : d & 255;
      wC = hit && w && idx == 2; wA = hit && w && idx == 3;
      wB = hit && w && idx == 4; wS = hit && w && idx == 1;
      wT = hit && w && idx == 0; rS = hit && !w && idx == 1;
      tk = rate_tick(m_sel[c], m_pre);
      eqa = (m_cnt[c] == m_ca[c]) && !wA;
      eqb = (m_cnt[c] == m_cb[c]) && !wB;
      eva = eqa && !m_eqa[c];
      evb = eqb && !m_eqb[c];
      clr = (m_clr[c] == 1 && eva) || (m_clr[c] == 2 && evb) || (m_clr[c] == 3 && ext_v[c]);
      ov = !wC && !clr && tk && m_cnt[c] == 255;
      setv[0] = eva; setv[1] = evb; setv[2] = ov;
      for (int i = 0; i < 3; i++) begin
        cur = m_flag[c][i];
        nf = setv[i] || (cur && !(wS && m_arm[c][i] && !((wdc >> i) & 1)));
        if (!nf) na = 0;
        else if (wS) na = 0;
        else if (rS && cur) na = 1;
        else na = m_arm[c][i];
        m_flag[c][i] = nf; m_arm[c][i] = na;
      end
      if (evb) m_tmo[c] = pin_next(m_tmo[c], m_osb[c]);
      else if (eva) m_tmo[c] = pin_next(m_tmo[c], m_osa[c]);
      if (wC) m_cnt[c] = wdc;
      else if (clr) m_cnt[c] = 0;
      else if (tk) m_cnt[c] = (m_cnt[c] + 1) & 255;
      if (wA) m_ca[c] = wdc;
      if (wB) m_cb[c] = wdc;
      if (wT) begin m_sel[c] = wdc & 7; m_clr[c] = (wdc >> 3) & 3; end
      if (wS) begin m_osa[c] = (wdc >> 3) & 3; m_osb[c] = (wdc >> 5) & 3; end
      m_eqa[c] = eqa; m_eqb[c] = eqb;
    end
    m_pre = (m_pre + 1) % 64;
  endtask

  // One clock cycle: drive, check pins and read data, advance the model
  task automatic cyc(bit s, bit w, bit wo, int a, int d, string tag);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_word = wo; bus_addr = a[3:0];
    bus_wdata = d[15:0]; ext_clr = ext_v;
    #1;
    chk("R8 tmo0", tmo[0], m_tmo[0]);
    chk("R8 tmo1", tmo[1], m_tmo[1]);
    if (s && !w) chk(tag, bus_rdata, exp_read(wo, a));
    model_step(s, w, wo, a, d);
  endtask

  task automatic wr(int a, int d, bit wo = 0);
    cyc(1, 1, wo, a, d, "");
  endtask
  task automatic rd(int a, string tag, bit wo = 0);
    cyc(1, 0, wo, a, 0, tag);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    ext_v = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values on both channels
    for (int a = 0; a < 10; a++) rd(a, "R1 reset value");

    // R10: paired word write and read, rate stopped
    wr(4, 16'h1234, 1);
    rd(4, "R10 word read", 1);
    chk("R10 literal", bus_rdata, 16'h1234);
    rd(5, "R10 low byte to ch1");
    rd(4, "R11 byte read ch0");
    chk("R11 literal", bus_rdata, 16'h0012);
    wr(14, 8'h77); rd(14, "R11 unused index");

    // R2: stopped, then divide by 4, then every clock
    idle(5); rd(4, "R2 stopped");
    wr(0, 3); idle(13); rd(4, "R2 divide by 4");
    wr(0, 7); idle(70); rd(4, "R2 divide by 64");
    wr(0, 1); idle(4); rd(4, "R2 every clock");

    // R3/R6: wrap through 0xFF sets overflow, write has priority
    wr(4, 8'hFD); idle(3); rd(2, "R3 overflow flag");
    wr(4, 8'h10); rd(4, "R6 written counter");

    // R9: unarmed clear ignored, armed clear works
    wr(2, 0); rd(2, "R9 unarmed write keeps flags");
    rd(2, "R9 arm read"); wr(2, 0); rd(2, "R9 armed clear");

    // R4/R5: ch1 clears on match A at 5
    wr(1, 1 | (1 << 3)); wr(7, 5); wr(5, 0);
    for (int i = 0; i < 12; i++) rd(5, "R5 clear on A");
    rd(3, "R4 flag A");

    // R7: write constant A equal to held counter
    wr(0, 0); wr(4, 8'h40); rd(2, "R7 arm"); wr(2, 0);
    wr(6, 8'h40); rd(2, "R7 match after write");
    wr(0, 1); rd(2, "R7 arm"); wr(2, 0);
    cyc(1, 1, 0, 6, 8'h45, ""); rd(2, "R7 suppressed in write cycle");

    // R8: ch0 high on A, low on B, clear on B
    wr(2, (2 << 3) | (1 << 5)); wr(6, 3); wr(8, 6); wr(0, 1 | (2 << 3)); wr(4, 0);
    idle(20);
    wr(6, 9); wr(8, 9); wr(4, 0); idle(12); rd(2, "R8 same cycle B wins");

    // R5: ch1 external clear
    wr(1, 1 | (3 << 3));
    idle(4); ext_v = 2'b10; idle(1); ext_v = 2'b00; rd(5, "R5 external clear");
    idle(3); ext_v = 2'b10; idle(3); rd(5, "R5 external held"); ext_v = 0;

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int r, a, d, idx;
      bit wo;
      r = $urandom % 100;
      ext_v = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      idx = $urandom % 6;
      a = (idx << 1) | ($urandom % 2);
      wo = ($urandom % 3) == 0;
      d = $urandom & 16'hFFFF;
      if (idx == 0) d = (($urandom % 3) | (($urandom % 4) << 3)) * 257;
      if (r < 45) idle(1);
      else if (r < 75) rd(a, "R11 random read", wo);
      else wr(a, d, wo);
    end

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule